// File: doc/BRIEF.md
# Seven-product 2x2 matrix multiplier

This block multiplies two 2x2 matrices of signed 16-bit integers. It does not form the eight row-by-column products. It first combines the quadrants of each operand into pre-sums and forms seven intermediate products from them. It then builds each of the four result entries from sums and differences of those seven products. One multiplication is removed, and several additions and subtractions take its place. Each element slot could later hold a sub-matrix, because the schedule is written entirely in terms of quadrant arithmetic.

A one-cycle start pulse captures all eight operand entries. A single registered multiplier then serves the seven products on consecutive cycles. A lane accumulator folds each product into the result entries it contributes to, adding or subtracting as needed. The busy output covers the whole run. A single-cycle done pulse marks that the four 34-bit signed results are final. The results then hold until the next start is accepted.

Top module: `strassen_mm2`

## Requirements
- R1: While `rst` is high at a clock edge, the block is idle after that edge, with `busy_o` and `done_o` low and all four result outputs zero.
- R2: A `start_i` high at a clock edge while `busy_o` is low is accepted: operands are captured at that edge and `busy_o` is high after it.
- R3: `done_o` goes high exactly 9 clock edges after the accepting edge and stays high for exactly one cycle.
- R4: After done, `c11_o = a11*b11 + a12*b21`, `c12_o = a11*b12 + a12*b22`, `c21_o = a21*b11 + a22*b21`, `c22_o = a21*b12 + a22*b22`, computed in signed arithmetic. Here `a11` is row 1 column 1, `a12` is row 1 column 2, `a21` is row 2 column 1 and `a22` is row 2 column 2, and the same holds for `b`.
- R5: Operands at the extremes of the 16-bit signed range (-32768 and 32767, in any mix) give exact results on the 34-bit signed outputs, with no wrap.
- R6: `start_i` while `busy_o` is high is ignored: operand inputs at that time do not affect the results, and the run is neither restarted nor lengthened.
- R7: Result outputs keep their values from the done cycle until the next accepted start.
- R8: `busy_o` stays high from the accepting edge until the edge that raises `done_o`, and is low in the done cycle.
- R9: A `start_i` presented in the done cycle is accepted at the next edge and starts a new run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, sampled while idle |
| a11_i | input | 16 | Left operand, row 1 column 1, signed |
| a12_i | input | 16 | Left operand, row 1 column 2, signed |
| a21_i | input | 16 | Left operand, row 2 column 1, signed |
| a22_i | input | 16 | Left operand, row 2 column 2, signed |
| b11_i | input | 16 | Right operand, row 1 column 1, signed |
| b12_i | input | 16 | Right operand, row 1 column 2, signed |
| b21_i | input | 16 | Right operand, row 2 column 1, signed |
| b22_i | input | 16 | Right operand, row 2 column 2, signed |
| busy_o | output | 1 | High while a multiplication is in progress |
| done_o | output | 1 | One-cycle pulse, results final |
| c11_o | output | 34 | Result row 1 column 1, signed |
| c12_o | output | 34 | Result row 1 column 2, signed |
| c21_o | output | 34 | Result row 2 column 1, signed |
| c22_o | output | 34 | Result row 2 column 2, signed |

## Verification
The hardest case to reach from the ports is a start that arrives in the final cycle of a run. The block is still busy then, yet it returns to idle at that same edge, so the start must be dropped. A second hard case is a start in the done cycle itself, which must be taken. The directed tests hold `start_i` high with different operands across the whole busy window, including that last busy cycle, and then check that the results match the first operands and that the latency is unchanged. A separate test raises start on the exact cycle where done is seen.

// File: rtl/strassen_pkg.sv
package strassen_pkg;

    localparam int unsigned NPROD = 7;
    localparam int unsigned TAG_W = 3;
    localparam int unsigned LANES = 4;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_DRAIN = 2'd2,
        ST_FIN   = 2'd3
    } mm_state_e;

    // Lane contribution codes
    localparam logic [1:0] CF_NONE = 2'b00;
    localparam logic [1:0] CF_ADD  = 2'b01;
    localparam logic [1:0] CF_SUB  = 2'b10;

    // Per product tag: contribution to lanes {c22, c21, c12, c11}
    function automatic logic [LANES-1:0][1:0] lane_coef(input logic [TAG_W-1:0] tag);
        logic [LANES-1:0][1:0] cf;
        cf = '{default: CF_NONE};
        case (tag)
            3'd0: begin cf[0] = CF_ADD; cf[3] = CF_ADD; end
            3'd1: begin cf[2] = CF_ADD; cf[3] = CF_SUB; end
            3'd2: begin cf[1] = CF_ADD; cf[3] = CF_ADD; end
            3'd3: begin cf[0] = CF_ADD; cf[2] = CF_ADD; end
            3'd4: begin cf[0] = CF_SUB; cf[1] = CF_ADD; end
            3'd5: begin cf[3] = CF_ADD; end
            3'd6: begin cf[0] = CF_ADD; end
            default: cf = '{default: CF_NONE};
        endcase
        return cf;
    endfunction

endpackage

// File: rtl/strassen_presum.sv
module strassen_presum #(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned SUM_W = DATA_W + 1
) (
    input  logic [3:0][DATA_W-1:0] opa_i,
    input  logic [3:0][DATA_W-1:0] opb_i,
    input  logic [2:0]             sel_i,
    output logic [SUM_W-1:0]       lhs_o,
    output logic [SUM_W-1:0]       rhs_o
);
    // Quadrant order in the packed arrays: 0 = r1c1, 1 = r1c2, 2 = r2c1, 3 = r2c2
    logic signed [SUM_W-1:0] xa [4];
    logic signed [SUM_W-1:0] xb [4];
    logic signed [SUM_W-1:0] l_s;
    logic signed [SUM_W-1:0] r_s;

    for (genvar q = 0; q < 4; q++) begin : g_ext
        assign xa[q] = SUM_W'($signed(opa_i[q]));
        assign xb[q] = SUM_W'($signed(opb_i[q]));
    end

    always_comb begin
        l_s = '0;
        r_s = '0;
        case (sel_i)
            3'd0: begin l_s = xa[0] + xa[3]; r_s = xb[0] + xb[3]; end
            3'd1: begin l_s = xa[2] + xa[3]; r_s = xb[0];         end
            3'd2: begin l_s = xa[0];         r_s = xb[1] - xb[3]; end
            3'd3: begin l_s = xa[3];         r_s = xb[2] - xb[0]; end
            3'd4: begin l_s = xa[0] + xa[1]; r_s = xb[3];         end
            3'd5: begin l_s = xa[2] - xa[0]; r_s = xb[0] + xb[1]; end
            3'd6: begin l_s = xa[1] - xa[3]; r_s = xb[2] + xb[3]; end
            default: begin l_s = '0; r_s = '0; end
        endcase
    end

    assign lhs_o = l_s;
    assign rhs_o = r_s;
endmodule

// File: rtl/strassen_mul.sv
module strassen_mul #(
    parameter int unsigned IN_W  = 17,
    parameter int unsigned TAG_W = 3,
    localparam int unsigned PROD_W = 2 * IN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vld_i,
    input  logic [TAG_W-1:0]  tag_i,
    input  logic [IN_W-1:0]   lhs_i,
    input  logic [IN_W-1:0]   rhs_i,
    output logic              vld_o,
    output logic [TAG_W-1:0]  tag_o,
    output logic [PROD_W-1:0] prod_o
);
    typedef struct packed {
        logic              vld;
        logic [TAG_W-1:0]  tag;
        logic [PROD_W-1:0] prod;
    } mul_reg_t;

    mul_reg_t r_d, r_q;
    logic signed [PROD_W-1:0] p_s;

    always_comb begin
        p_s      = $signed(lhs_i) * $signed(rhs_i);
        r_d      = r_q;
        r_d.vld  = vld_i;
        if (vld_i) begin
            r_d.tag  = tag_i;
            r_d.prod = p_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign vld_o  = r_q.vld;
    assign tag_o  = r_q.tag;
    assign prod_o = r_q.prod;
endmodule

// File: rtl/strassen_acc.sv
module strassen_acc
    import strassen_pkg::*;
#(
    parameter int unsigned PROD_W = 34,
    parameter int unsigned RES_W  = 34
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        clr_i,
    input  logic                        vld_i,
    input  logic [TAG_W-1:0]            tag_i,
    input  logic [PROD_W-1:0]           prod_i,
    output logic [LANES-1:0][RES_W-1:0] res_o
);
    typedef struct packed {
        logic [LANES-1:0][RES_W-1:0] acc;
    } acc_reg_t;

    acc_reg_t r_d, r_q;
    logic signed [RES_W-1:0] pext;
    logic [LANES-1:0][1:0]   cf;

    assign pext = RES_W'($signed(prod_i));
    assign cf   = lane_coef(tag_i);

    always_comb begin
        r_d = r_q;
        if (clr_i) begin
            r_d.acc = '0;
        end else if (vld_i) begin
            for (int ln = 0; ln < int'(LANES); ln++) begin
                case (cf[ln])
                    CF_ADD:  r_d.acc[ln] = r_q.acc[ln] + pext;
                    CF_SUB:  r_d.acc[ln] = r_q.acc[ln] - pext;
                    default: r_d.acc[ln] = r_q.acc[ln];
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign res_o = r_q.acc;
endmodule

// File: rtl/strassen_mm2.sv
module strassen_mm2
    import strassen_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    localparam int unsigned SUM_W  = DATA_W + 1,
    localparam int unsigned PROD_W = 2 * SUM_W,
    localparam int unsigned RES_W  = PROD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic [DATA_W-1:0] a11_i,
    input  logic [DATA_W-1:0] a12_i,
    input  logic [DATA_W-1:0] a21_i,
    input  logic [DATA_W-1:0] a22_i,
    input  logic [DATA_W-1:0] b11_i,
    input  logic [DATA_W-1:0] b12_i,
    input  logic [DATA_W-1:0] b21_i,
    input  logic [DATA_W-1:0] b22_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [RES_W-1:0]  c11_o,
    output logic [RES_W-1:0]  c12_o,
    output logic [RES_W-1:0]  c21_o,
    output logic [RES_W-1:0]  c22_o
);
    localparam logic [TAG_W-1:0] LAST_TAG = TAG_W'(NPROD - 1);

    typedef struct packed {
        mm_state_e               st;
        logic [TAG_W-1:0]        idx;
        logic [3:0][DATA_W-1:0]  opa;
        logic [3:0][DATA_W-1:0]  opb;
        logic                    done;
    } ctl_reg_t;

    ctl_reg_t r_d, r_q;
    logic     clr_d;
    logic     issue_d;

    logic [SUM_W-1:0]            lhs, rhs;
    logic                        pvld;
    logic [TAG_W-1:0]            ptag;
    logic [PROD_W-1:0]           prod;
    logic [LANES-1:0][RES_W-1:0] res;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        clr_d    = 1'b0;
        issue_d  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start_i) begin
                    r_d.opa = {a22_i, a21_i, a12_i, a11_i};
                    r_d.opb = {b22_i, b21_i, b12_i, b11_i};
                    r_d.idx = '0;
                    r_d.st  = ST_ISSUE;
                    clr_d   = 1'b1;
                end
            end
            ST_ISSUE: begin
                issue_d = 1'b1;
                if (r_q.idx == LAST_TAG) r_d.st = ST_DRAIN;
                else                     r_d.idx = r_q.idx + 1'b1;
            end
            ST_DRAIN: r_d.st = ST_FIN;
            ST_FIN: begin
                r_d.st   = ST_IDLE;
                r_d.done = 1'b1;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '{st: ST_IDLE, default: '0};
        else     r_q <= r_d;
    end

    strassen_presum #(.DATA_W(DATA_W)) presum_i (
        .opa_i (r_q.opa),
        .opb_i (r_q.opb),
        .sel_i (r_q.idx),
        .lhs_o (lhs),
        .rhs_o (rhs)
    );

    strassen_mul #(.IN_W(SUM_W), .TAG_W(TAG_W)) mul_i (
        .clk    (clk),
        .rst    (rst),
        .vld_i  (issue_d),
        .tag_i  (r_q.idx),
        .lhs_i  (lhs),
        .rhs_i  (rhs),
        .vld_o  (pvld),
        .tag_o  (ptag),
        .prod_o (prod)
    );

    strassen_acc #(.PROD_W(PROD_W), .RES_W(RES_W)) acc_i (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (clr_d),
        .vld_i  (pvld),
        .tag_i  (ptag),
        .prod_i (prod),
        .res_o  (res)
    );

    assign busy_o = (r_q.st != ST_IDLE);
    assign done_o = r_q.done;
    assign c11_o  = res[0];
    assign c12_o  = res[1];
    assign c21_o  = res[2];
    assign c22_o  = res[3];
endmodule

// File: rtl/strassen_mm2_chk.sv
module strassen_mm2_chk #(
    parameter int unsigned RES_W = 34
) (
    input logic             clk,
    input logic             rst,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic [RES_W-1:0] c11_o,
    input logic [RES_W-1:0] c12_o,
    input logic [RES_W-1:0] c21_o,
    input logic [RES_W-1:0] c22_o
);
    logic [7:0] busy_run;

    always_ff @(posedge clk) begin
        if (rst)         busy_run <= '0;
        else if (busy_o) busy_run <= busy_run + 8'd1;
        else             busy_run <= '0;
    end

    AST_RESET_IDLE: assert property (@(posedge clk)
        rst |=> (!busy_o && !done_o && c11_o == '0 && c12_o == '0 && c21_o == '0 && c22_o == '0)); // R1

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
        (!busy_o && start_i) |=> busy_o); // R2

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o); // R3

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (busy_run == 8'd9)); // R3

    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (busy_o && start_i) |=> (busy_o || done_o)); // R6

    AST_RESULTS_HELD: assert property (@(posedge clk) disable iff (rst)
        ($past(!busy_o) && !busy_o) |-> ($stable(c11_o) && $stable(c12_o) && $stable(c21_o) && $stable(c22_o))); // R7

    AST_BUSY_ENDS_AT_DONE: assert property (@(posedge clk) disable iff (rst)
        $fell(busy_o) |-> done_o); // R8

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o); // R8
endmodule

bind strassen_mm2 strassen_mm2_chk #(.RES_W(RES_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start_i (start_i),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .c11_o   (c11_o),
    .c12_o   (c12_o),
    .c21_o   (c21_o),
    .c22_o   (c22_o)
);

// File: tb/strassen_mm2_tb_top.sv
`timescale 1ns/1ps
module strassen_mm2_tb_top;
    localparam int DW = 16;
    localparam int RW = 34;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic [DW-1:0] a11_i = '0, a12_i = '0, a21_i = '0, a22_i = '0;
    logic [DW-1:0] b11_i = '0, b12_i = '0, b21_i = '0, b22_i = '0;
    logic busy_o, done_o;
    logic [RW-1:0] c11_o, c12_o, c21_o, c22_o;

    int n_run  = 0;
    int n_fail = 0;
    int cyc    = 0;

    always #4 clk = ~clk;

    strassen_mm2 #(.DATA_W(DW)) dut_i (
        .clk(clk), .rst(rst), .start_i(start_i),
        .a11_i(a11_i), .a12_i(a12_i), .a21_i(a21_i), .a22_i(a22_i),
        .b11_i(b11_i), .b12_i(b12_i), .b21_i(b21_i), .b22_i(b22_i),
        .busy_o(busy_o), .done_o(done_o),
        .c11_o(c11_o), .c12_o(c12_o), .c21_o(c21_o), .c22_o(c22_o)
    );

    function automatic longint sx(input logic [RW-1:0] v);
        return longint'($signed(v));
    endfunction

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_ops(input longint a0, a1, a2, a3, b0, b1, b2, b3);
        a11_i = DW'(a0); a12_i = DW'(a1); a21_i = DW'(a2); a22_i = DW'(a3);
        b11_i = DW'(b0); b12_i = DW'(b1); b21_i = DW'(b2); b22_i = DW'(b3);
    endtask

    // Present start with operands at a negedge, return at the negedge after the accepting edge
    task automatic launch(input longint a0, a1, a2, a3, b0, b1, b2, b3, input string req);
        drive_ops(a0, a1, a2, a3, b0, b1, b2, b3);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, req, longint'(busy_o), 1);
    endtask

    // Count edges until done; busy must hold meanwhile (R8)
    task automatic wait_done(output int n);
        n = 0;
        while (n < 30) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (done_o === 1'b1) break;
            if (busy_o !== 1'b1) check(1'b0, "R8 busy dropped", longint'(busy_o), 1);
        end
        check(busy_o === 1'b0, "R8 busy low at done", longint'(busy_o), 0);
    endtask

    task automatic check_res(input longint a0, a1, a2, a3, b0, b1, b2, b3, input string req);
        check(sx(c11_o) == a0*b0 + a1*b2, {req, " c11"}, sx(c11_o), a0*b0 + a1*b2);
        check(sx(c12_o) == a0*b1 + a1*b3, {req, " c12"}, sx(c12_o), a0*b1 + a1*b3);
        check(sx(c21_o) == a2*b0 + a3*b2, {req, " c21"}, sx(c21_o), a2*b0 + a3*b2);
        check(sx(c22_o) == a2*b1 + a3*b3, {req, " c22"}, sx(c22_o), a2*b1 + a3*b3);
    endtask

    task automatic run_op(input longint a0, a1, a2, a3, b0, b1, b2, b3, input string req);
        int n;
        launch(a0, a1, a2, a3, b0, b1, b2, b3, "R2 busy after start");
        wait_done(n);
        check(n == 9, "R3 latency", longint'(n), 9);
        check_res(a0, a1, a2, a3, b0, b1, b2, b3, req);
        @(posedge clk);
        @(negedge clk);
        check(done_o === 1'b0, "R3 done one cycle", longint'(done_o), 0);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        check(busy_o === 1'b0, "R1 busy", longint'(busy_o), 0);
        check(done_o === 1'b0, "R1 done", longint'(done_o), 0);
        check(sx(c11_o) == 0 && sx(c22_o) == 0, "R1 results", sx(c11_o), 0);
    endtask

    task automatic t_basic();
        run_op(1, 2, 3, 4, 5, 6, 7, 8, "R4 small positive");
        run_op(-3, 7, 11, -2, 9, -4, -6, 5, "R4 mixed sign");
        run_op(1, 0, 0, 1, 123, -456, 789, -1011, "R4 identity");
        run_op(0, 0, 0, 0, 3, 3, 3, 3, "R4 zero");
    endtask

    task automatic t_extreme();
        run_op(-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768, "R5 all min");
        run_op(32767, -32768, -32768, 32767, -32768, 32767, 32767, -32768, "R5 max min mix");
        run_op(32767, 32767, 32767, 32767, 32767, 32767, 32767, 32767, "R5 all max");
    endtask

    task automatic t_ignore();
        int n;
        launch(2, -5, 7, 1, 3, 4, -8, 6, "R2 busy after start");
        drive_ops(999, 999, -999, 999, 999, -999, 999, 999);
        start_i = 1'b1;
        n = 0;
        while (n < 30) begin
            @(posedge clk);
            @(negedge clk);
            n++;
            if (done_o === 1'b1) break;
        end
        start_i = 1'b0;
        check(n == 9, "R6 latency unchanged", longint'(n), 9);
        check_res(2, -5, 7, 1, 3, 4, -8, 6, "R6 ignored operands");
        @(posedge clk);
        @(negedge clk);
        check(busy_o === 1'b0, "R6 no restart", longint'(busy_o), 0);
    endtask

    task automatic t_hold();
        longint h11, h22;
        run_op(10, -20, 30, -40, 50, 60, -70, 80, "R4 before hold");
        h11 = sx(c11_o);
        h22 = sx(c22_o);
        drive_ops(1, 1, 1, 1, 1, 1, 1, 1);
        repeat (6) @(posedge clk);
        @(negedge clk);
        check(sx(c11_o) == h11, "R7 c11 held", sx(c11_o), h11);
        check(sx(c22_o) == h22, "R7 c22 held", sx(c22_o), h22);
        check(done_o === 1'b0, "R7 no done", longint'(done_o), 0);
    endtask

    task automatic t_b2b();
        int n;
        launch(4, 3, 2, 1, -1, -2, -3, -4, "R2 busy after start");
        wait_done(n);
        check_res(4, 3, 2, 1, -1, -2, -3, -4, "R4 first of pair");
        drive_ops(-7, 8, 9, -10, 11, 12, -13, 14);
        start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        check(busy_o === 1'b1, "R9 start in done cycle", longint'(busy_o), 1);
        wait_done(n);
        check(n == 9, "R9 latency", longint'(n), 9);
        check_res(-7, 8, 9, -10, 11, 12, -13, 14, "R9 second of pair");
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_run++;
                n_fail++;
                $display("FAIL R3 watchdog actual=hung expected=finished");
                $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
                $finish;
            end
        end
    end

    initial begin
        t_reset();
        t_basic();
        t_extreme();
        t_ignore();
        t_hold();
        t_b2b();
        repeat (2) @(posedge clk);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule